// File: doc/BRIEF.md
# Grouped Weighted-Threshold Carry Adder

This block is a clock-accurate digital model of an n-bit adder that resolves carries four bits at a time. For each 4-bit group it captures the group's eight operand bits together with the carry entering the group. On the next clock it folds them into one weighted level, where the incoming carry and bit 0 of each operand count 1, bit 1 counts 2, bit 2 counts 4 and bit 3 counts 8. In the following stage it compares that level against a fixed threshold, which yields the carry out of the group. The same stage also captures the operands of the next group, using the carry just produced. Once every group carry is known, all 4-bit group sums are formed at once.

A run starts with a one-clock `start_i` pulse while the block is idle or finished. Each stage lasts two clocks: a capture half and a fold half. A stage counter reports progress. The result is complete, and `done_o` rises, when the counter reaches WIDTH/4+5. For the default width of 16 that is 9 stages. The FSM states are IDLE (waiting), READ (capture a group, and resolve the previous group's carry when there is one), SHARE (fold the captured bits into a level), RESOLVE (compare the last group's level to produce the final carry), SUM (form every group sum in parallel), SETTLE (pad stages up to the final count) and DONE (hold the result). The transitions are IDLE→READ on start, READ→SHARE, SHARE→READ while groups remain, SHARE→RESOLVE after the last group, RESOLVE→SUM, SUM→SETTLE, SETTLE→DONE when the counter reaches its final value, and DONE→READ on a new start.

Top module: `grouped_threshold_adder`

## Requirements
- R1: After reset `sum_o` and `cout_o` are 0, `done_o` is 0 and `stage_o` is 0.
- R2: A group's carry out is 1 exactly when cin + a0 + b0 + 2(a1+b1) + 4(a2+b2) + 8(a3+b3) is 16 or more. For example, a group with a=4'b1111, b=4'b0000 and an incoming carry of 1 produces a carry of 1.
- R3: When `done_o` is high, {`cout_o`, `sum_o`} equals A + B + CIN for the operands captured at start.
- R4: The clock edge that accepts start sets `stage_o` to 1. After that, `stage_o` rises by exactly one on every second clock edge while the run is in progress.
- R5: `done_o` rises on the clock edge where `stage_o` becomes WIDTH/4+5, which is 2·(WIDTH/4+4) clock edges after the edge that accepts start (16 edges for WIDTH=16). `done_o` is never high at any other stage value.
- R6: A `start_i` pulse that arrives while a run is in progress is ignored. The running result and its timing are unchanged.
- R7: While `done_o` is high and `start_i` is low, `sum_o`, `cout_o`, `done_o` and `stage_o` hold their values. A start pulse in this state begins a new run.
- R8: With A=16'b1011_0111_1010_1100, B=16'b0100_0011_0111_1001 and CIN=1, the result is carry 0 and sum 16'b1111_1011_0010_0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run. Accepted in IDLE or DONE only |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry in |
| sum_o | output | WIDTH | Sum result |
| cout_o | output | 1 | Carry out of the top group |
| done_o | output | 1 | Result valid |
| stage_o | output | $clog2(WIDTH/4+6) | Stage counter |

## Verification
The embedded assertions check the following on every cycle:
- the counter steps once per two clocks during a run;
- `done_o` appears only at the final stage value;
- the finished result equals the arithmetic sum of the captured operands;
- the result holds steady while finished;
- the counter is zero while idle.

Only the bench's scenarios can show the rest:
- the exact latency measured from the start edge;
- that a mid-run start leaves both the result and its timing unchanged;
- that the threshold boundary case yields a group carry;
- that results match an independent model across random and corner operands.

// File: rtl/gta_pkg.sv
package gta_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_SHARE,
        S_RESOLVE,
        S_SUM,
        S_SETTLE,
        S_DONE
    } gta_state_e;

endpackage

// File: rtl/gta_weigh.sv
// Folds one group's captured bits into a single weighted level.
// Bit 0 of vec is the incoming carry; bits 2k+1 and 2k+2 are a[k] and b[k].
module gta_weigh #(
    parameter int GW = 4,
    localparam int LW = GW + 1
) (
    input  logic [2*GW:0]  vec,
    output logic [LW-1:0]  level
);

    always_comb begin
        level = LW'(vec[0]);
        for (int k = 0; k < GW; k++) begin
            level = level + (LW'(vec[2*k+1]) << k) + (LW'(vec[2*k+2]) << k);
        end
    end

endmodule

// File: rtl/gta_group_add.sv
// One group's parallel sum from its own incoming carry.
module gta_group_add #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          cin,
    output logic [GW-1:0] sum
);

    always_comb begin
        sum = a + b + GW'(cin);
    end

endmodule

// File: rtl/grouped_threshold_adder.sv
module grouped_threshold_adder
    import gta_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int GW         = 4,
    localparam int NG         = WIDTH / GW,
    localparam int DONE_STAGE = NG + 5,
    localparam int SW         = $clog2(DONE_STAGE + 1),
    localparam int LW         = GW + 1,
    localparam int GIW        = (NG > 1) ? $clog2(NG) : 1,
    localparam int THRESH     = 1 << GW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             done_o,
    output logic [SW-1:0]    stage_o
);

    gta_state_e state_q, state_d;

    logic             half_q;
    logic [SW-1:0]    stage_q;
    logic [GIW-1:0]   grp_q;
    logic [WIDTH-1:0] a_q, b_q;
    logic [NG:0]      carry_q;
    logic [2*GW:0]    cap_q, cap_d;
    logic [LW-1:0]    level_q, level_w;
    logic [WIDTH-1:0] sum_q, sum_w;
    logic             thr_w, grp_cin_w, busy_w, accept_w, last_grp_w;

    assign busy_w     = (state_q != S_IDLE) && (state_q != S_DONE);
    assign accept_w   = start_i && !busy_w;
    assign thr_w      = (level_q >= LW'(THRESH));
    assign last_grp_w = (grp_q == GIW'(NG - 1));
    assign grp_cin_w  = (grp_q == '0) ? carry_q[0] : thr_w;

    // Capture vector for the current group: carry, then a/b pairs by weight.
    always_comb begin
        cap_d[0] = grp_cin_w;
        for (int k = 0; k < GW; k++) begin
            cap_d[2*k+1] = a_q[grp_q*GW + k];
            cap_d[2*k+2] = b_q[grp_q*GW + k];
        end
    end

    gta_weigh #(.GW(GW)) u_weigh (
        .vec   (cap_q),
        .level (level_w)
    );

    for (genvar g = 0; g < NG; g++) begin : g_grp
        gta_group_add #(.GW(GW)) u_add (
            .a   (a_q[g*GW +: GW]),
            .b   (b_q[g*GW +: GW]),
            .cin (carry_q[g]),
            .sum (sum_w[g*GW +: GW])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_READ;
            S_READ:    state_d = S_SHARE;
            S_SHARE:   state_d = last_grp_w ? S_RESOLVE : S_READ;
            S_RESOLVE: state_d = S_SUM;
            S_SUM:     state_d = S_SETTLE;
            S_SETTLE:  if (half_q && stage_q == SW'(DONE_STAGE - 1)) state_d = S_DONE;
            S_DONE:    if (start_i) state_d = S_READ;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= 1'b0;
            stage_q <= '0;
            grp_q   <= '0;
            a_q     <= '0;
            b_q     <= '0;
            carry_q <= '0;
            cap_q   <= '0;
            level_q <= '0;
            sum_q   <= '0;
        end else if (accept_w) begin
            half_q     <= 1'b0;
            stage_q    <= SW'(1);
            grp_q      <= '0;
            a_q        <= a_i;
            b_q        <= b_i;
            carry_q    <= '0;
            carry_q[0] <= cin_i;
            level_q    <= '0;
        end else if (busy_w) begin
            half_q <= ~half_q;
            if (half_q) stage_q <= stage_q + SW'(1);
            unique case (state_q)
                S_READ: begin
                    cap_q          <= cap_d;
                    carry_q[grp_q] <= grp_cin_w;
                end
                S_SHARE: begin
                    level_q <= level_w;
                    if (!last_grp_w) grp_q <= grp_q + GIW'(1);
                end
                S_RESOLVE: carry_q[NG] <= thr_w;
                S_SUM:     sum_q       <= sum_w;
                default: ;
            endcase
        end
    end

    assign sum_o   = sum_q;
    assign cout_o  = carry_q[NG];
    assign done_o  = (state_q == S_DONE);
    assign stage_o = stage_q;

    // R1
    idle_stage_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (stage_o == '0 && !done_o));

    // R4
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && half_q && !start_i) |=> (stage_o == $past(stage_o) + SW'(1)));

    // R5
    done_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (stage_o == SW'(DONE_STAGE)));

    // R3
    result_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({cout_o, sum_o} == ({1'b0, a_q} + {1'b0, b_q} + (WIDTH+1)'(carry_q[0]))));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(sum_o) && $stable(cout_o) && $stable(stage_o)));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && start_i) |=> ($stable(a_q) && $stable(b_q)));

endmodule

// File: tb/grouped_threshold_adder_bench.sv
module grouped_threshold_adder_bench;

    localparam int WIDTH = 16;
    localparam int NG    = WIDTH / 4;
    localparam int SW    = $clog2(NG + 6);
    localparam int LAT   = 2 * (NG + 4);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [WIDTH-1:0] a_i = '0, b_i = '0;
    logic             cin_i = 1'b0;
    logic [WIDTH-1:0] sum_o;
    logic             cout_o, done_o;
    logic [SW-1:0]    stage_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [WIDTH:0] exp_q[$];
    logic done_prev = 1'b0;

    always #5 clk = ~clk;

    grouped_threshold_adder #(.WIDTH(WIDTH)) u_grouped_threshold_adder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o), .done_o(done_o), .stage_o(stage_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected results when done rises (R3, R8, R2)
    always @(negedge clk) begin
        cycles++;
        if (rst_n && done_o && !done_prev) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected result", 32'(sum_o), 32'hFFFF_FFFF);
            end else begin
                logic [WIDTH:0] e;
                e = exp_q.pop_front();
                check("R3 result", 32'({cout_o, sum_o}), 32'(e));
            end
        end
        done_prev = done_o;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Driver: starts a run, pushes the expected value, tracks stage/latency.
    // poke: drive a second start with other operands mid-run (R6).
    task automatic run(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic c, input bit poke);
        int n;
        bit stage_bad;
        @(negedge clk);
        a_i = a; b_i = b; cin_i = c; start_i = 1'b1;
        exp_q.push_back({1'b0, a} + {1'b0, b} + (WIDTH+1)'(c));
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        stage_bad = 0;
        while (!done_o && n < 100) begin
            if (poke && n == 4) begin
                a_i = ~a; b_i = ~b; cin_i = ~c; start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            n++;
            if (stage_o != SW'(n / 2 + 1)) stage_bad = 1;
        end
        // R4 counter steps once per two edges
        check("R4 stage sequence", 32'(stage_bad), 0);
        // R5 latency and final stage
        check("R5 latency", n, LAT);
        check("R5 final stage", 32'(stage_o), NG + 5);
    endtask

    initial begin
        // R1 reset state
        #12;
        check("R1 sum", 32'(sum_o), 0);
        check("R1 cout", 32'(cout_o), 0);
        check("R1 done", 32'(done_o), 0);
        check("R1 stage", 32'(stage_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle stage", 32'(stage_o), 0);

        // R8 stated vector
        run(16'b1011_0111_1010_1100, 16'b0100_0011_0111_1001, 1'b1, 0);
        check("R8 sum", 32'(sum_o), 32'b1111_1011_0010_0110);
        check("R8 cout", 32'(cout_o), 0);

        // R2 threshold boundary: group 0 level exactly 16
        run(16'h000F, 16'h0000, 1'b1, 0);
        check("R2 carry into group 1", 32'(sum_o), 32'h0010);
        // R2 just below threshold: level 15, no group carry
        run(16'h000F, 16'h0000, 1'b0, 0);
        check("R2 below threshold", 32'(sum_o), 32'h000F);

        // R3 corners
        run('1, '0, 1'b1, 0);
        check("R3 full ripple cout", 32'(cout_o), 1);
        run('0, '0, 1'b0, 0);
        run('1, '1, 1'b1, 0);

        // R7 hold after done, then restart from DONE
        repeat (5) @(negedge clk);
        check("R7 hold done", 32'(done_o), 1);
        check("R7 hold sum", 32'(sum_o), 32'hFFFF);
        check("R7 hold stage", 32'(stage_o), NG + 5);

        // R6 mid-run start ignored (result and timing checked in run)
        run(16'h1234, 16'hABCD, 1'b0, 1);
        check("R6 result unchanged", 32'({cout_o, sum_o}), 32'h0BE01);

        // R3 random operands
        for (int i = 0; i < 20; i++) begin
            run(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom), 0);
        end

        repeat (3) @(negedge clk);
        check("R3 queue drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule